// File: doc/BRIEF.md
# Interrupt Presenter Register Window

This block is the per-thread register window that a processor thread uses to talk to its interrupt presenter. A bus master addresses a 4 KB window with byte, halfword, word or doubleword accesses. The lower half of the window holds four 16-byte rings of byte-wide presenter state. The rings are user at 0x000, OS at 0x010, pool at 0x020 and physical at 0x030. Within a ring, byte +1 is the current processor priority and byte +7 is the pipelined priority; the remaining bytes hold notification status, pending buffer, backlog, acknowledge count, increment and age. The upper half, from 0x800 upward, holds no storage. It decodes command operations such as the OS acknowledge.

Only the OS ring is serviced. A normal access is honoured only when address bit 4 is set. Storage is indexed by the low six address bits, so a read at 0x030 returns physical-ring bytes. Reads must be naturally aligned. Only the OS current-priority byte at 0x011 can be written. A byte store to that address clamps any priority above 7 to 0xFF. Word and doubleword stores that cover it write their lane unchanged. Every other access shape is refused. An error flag or an unimplemented flag pulses together with the response. Event queues, sources and delivery of interrupts to the core are handled elsewhere.

Top module: `ipr_window`

## Requirements
- R1: After reset the OS current-priority byte (0x011) reads 0xFF and every other storage byte reads 0x00.
- R2: req_ready is always high. Each request with req_valid high produces exactly one response (rsp_valid high) on the following cycle, and rsp_valid is low otherwise.
- R3: A normal read (address below 0x800, bit 4 set) of size code 0/1/2/3 (1/2/4/8 bytes) at a naturally aligned address returns storage byte addr+i in bits [8i+7:8i]. Bits above the access size are zero.
- R4: A normal read at an address not aligned to its size returns all-ones with rsp_err high.
- R5: A byte write to 0x011 stores the written value when it is at most 7, and stores 0xFF otherwise.
- R6: An aligned word or doubleword write updates only the byte at 0x011 (taken from lane 0x011 minus address), stores that lane unclamped, and raises no flag.
- R7: Halfword writes, unaligned word or doubleword writes, and byte writes to any address other than 0x011 raise rsp_err and change no storage.
- R8: An access below 0x800 with address bit 4 clear raises rsp_unimp. On a read it returns all-ones. It changes no storage.
- R9: A halfword read at 0x810 returns zero with no flag. Any other read at 0x800 or above returns all-ones with rsp_err.
- R10: Writes at 0x800 or above raise no flag and change no storage.
- R11: rsp_err and rsp_unimp are never high together and are only high while rsp_valid is high. Write responses return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 2 | Access size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_wdata | input | 64 | Store data, byte lane i maps to address+i |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 64 | Load data |
| rsp_err | output | 1 | Illegal access pulse |
| rsp_unimp | output | 1 | Non-serviced ring pulse |

## Verification
The only state is the OS priority byte. A wrong value there, whether from a missed clamp, a stray lane write or a refused store that still landed, appears in the data of the next normal read covering 0x011. The bench therefore reads the byte back right after every store it makes. A wrong access classification shows up at the first response cycle as a wrong flag or as all-ones in place of data. Response timing errors show at once as a missing or extra rsp_valid.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 64;
    localparam int LANES       = DATA_W / 8;
    localparam int RING_BYTES  = 16;
    localparam int NUM_RINGS   = 4;
    localparam int STORE_BYTES = RING_BYTES * NUM_RINGS;
    localparam int IDX_W       = $clog2(STORE_BYTES);
    localparam int SERVE_BIT   = $clog2(RING_BYTES);
    localparam int CMD_BIT     = ADDR_W - 1;
    localparam int PRIO_OFS    = 1;
    localparam int PRIO_IDX    = RING_BYTES + PRIO_OFS;
    localparam logic [ADDR_W-1:0] PRIO_ADDR = ADDR_W'(PRIO_IDX);
    localparam logic [ADDR_W-1:0] ACK_ADDR  = 12'h810;
    localparam logic [7:0] MAX_PRIO  = 8'd7;
    localparam logic [7:0] PRIO_IDLE = 8'hFF;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ACK_READ,
        OP_CMD_BAD_READ,
        OP_CMD_WRITE,
        OP_UNSERVED,
        OP_READ,
        OP_BAD_READ,
        OP_PRIO_BYTE,
        OP_WIDE_WRITE,
        OP_BAD_WRITE
    } op_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic              unimp;
    } rsp_t;
endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
    import ipr_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output op_e               op
);
    logic [2:0] align_mask;
    logic       aligned;
    logic       is_cmd;
    logic       served;

    always_comb begin
        align_mask = 3'((4'd1 << size) - 4'd1);
        aligned    = (addr[2:0] & align_mask) == 3'd0;
        is_cmd     = addr[CMD_BIT];
        served     = addr[SERVE_BIT];
        op         = OP_NONE;
        if (valid) begin
            if (is_cmd) begin
                if (write)
                    op = OP_CMD_WRITE;
                else if (addr == ACK_ADDR && size == 2'd1)
                    op = OP_ACK_READ;
                else
                    op = OP_CMD_BAD_READ;
            end else if (!served) begin
                op = OP_UNSERVED;
            end else if (!write) begin
                op = aligned ? OP_READ : OP_BAD_READ;
            end else begin
                unique case (size)
                    2'd0:    op = (addr == PRIO_ADDR) ? OP_PRIO_BYTE : OP_BAD_WRITE;
                    2'd1:    op = OP_BAD_WRITE;
                    default: op = aligned ? OP_WIDE_WRITE : OP_BAD_WRITE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ipr_store.sv
module ipr_store
    import ipr_pkg::*;
#(
    parameter int NBYTES = STORE_BYTES,
    parameter int RW_IDX = PRIO_IDX,
    parameter logic [7:0] RW_RESET = PRIO_IDLE,
    localparam int IW = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic [7:0]        byte_val,
    input  logic              wide_we,
    input  logic [IW-1:0]     wide_base,
    input  logic [3:0]        wide_nbytes,
    input  logic [DATA_W-1:0] wide_data,
    input  logic [IW-1:0]     rd_base,
    input  logic [3:0]        rd_nbytes,
    output logic [DATA_W-1:0] rd_data
);
    logic [7:0] bytes_v [NBYTES];

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        if (b == RW_IDX) begin : g_rw
            logic [IW-1:0] lane;
            logic          wide_hit;
            logic [7:0]    val_d, val_q;

            always_comb begin
                lane     = IW'(b) - wide_base;
                wide_hit = wide_we && ({{(8-IW){1'b0}}, lane} < {4'd0, wide_nbytes});
                val_d    = val_q;
                if (byte_we)
                    val_d = (byte_val > MAX_PRIO) ? PRIO_IDLE : byte_val;
                else if (wide_hit)
                    val_d = wide_data[8*lane[2:0] +: 8];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= RW_RESET;
                else        val_q <= val_d;
            end

            assign bytes_v[b] = val_q;

            assert_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
                byte_we |=> (val_q <= MAX_PRIO || val_q == PRIO_IDLE));
            assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!byte_we && !wide_hit) |=> $stable(val_q));
        end else begin : g_ro
            assign bytes_v[b] = 8'h00;
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic [IW-1:0] idx;
            idx = rd_base + IW'(i);
            rd_data[8*i +: 8] = (4'(i) < rd_nbytes) ? bytes_v[idx] : 8'h00;
        end
    end
endmodule

// File: rtl/ipr_window.sv
module ipr_window
    import ipr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              rsp_unimp
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    op_e               op;
    logic [3:0]        nbytes;
    logic [DATA_W-1:0] store_rd;
    rsp_t              rsp_d, rsp_q;

    assign req_ready = 1'b1;
    assign nbytes    = 4'd1 << req_size;

    ipr_decode u_decode (
        .valid (req_valid),
        .write (req_write),
        .addr  (req_addr),
        .size  (req_size),
        .op    (op)
    );

    ipr_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_we     (op == OP_PRIO_BYTE),
        .byte_val    (req_wdata[7:0]),
        .wide_we     (op == OP_WIDE_WRITE),
        .wide_base   (req_addr[IDX_W-1:0]),
        .wide_nbytes (nbytes),
        .wide_data   (req_wdata),
        .rd_base     (req_addr[IDX_W-1:0]),
        .rd_nbytes   (nbytes),
        .rd_data     (store_rd)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        unique case (op)
            OP_READ:         rsp_d.rdata = store_rd;
            OP_BAD_READ,
            OP_CMD_BAD_READ: begin
                rsp_d.rdata = ALL_ONES;
                rsp_d.err   = 1'b1;
            end
            OP_BAD_WRITE:    rsp_d.err = 1'b1;
            OP_UNSERVED: begin
                rsp_d.unimp = 1'b1;
                rsp_d.rdata = req_write ? '0 : ALL_ONES;
            end
            default:         rsp_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;
    assign rsp_err   = rsp_q.err;
    assign rsp_unimp = rsp_q.unimp;

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_idle_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_flag_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err || rsp_unimp) |-> (rsp_valid && !(rsp_err && rsp_unimp)));
    assert_cmd_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[CMD_BIT]) |=> (!rsp_err && !rsp_unimp));
    assert_unserved_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_addr[CMD_BIT] && !req_addr[SERVE_BIT])
        |=> (rsp_unimp && rsp_rdata == ALL_ONES));
endmodule

// File: tb/ipr_window_test.sv
module ipr_window_test;
    localparam time CLK_PERIOD = 10;
    localparam logic [63:0] ONES = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;
    logic        rsp_unimp;

    int checks = 0;
    int errors = 0;
    logic [63:0] g_data;
    logic        g_err, g_unimp, g_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipr_window uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .rsp_unimp(rsp_unimp)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [1:0] s,
                          input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        @(posedge clk);
        #1;
        g_valid = rsp_valid; g_data = rsp_rdata; g_err = rsp_err; g_unimp = rsp_unimp;
        req_valid = 1'b0;
    endtask

    task automatic read_prio(input string req, input logic [7:0] exp);
        access(1'b0, 12'h011, 2'd0, '0);
        chk(req, g_data, {56'd0, exp});
    endtask

    task automatic t_reset;
        access(1'b0, 12'h010, 2'd3, '0);
        chk("R1 dword 0x010", g_data, 64'h0000_0000_0000_FF00);
        chk("R1 flags", {62'd0, g_err, g_unimp}, 64'd0);
        access(1'b0, 12'h018, 2'd3, '0);
        chk("R1 dword 0x018", g_data, 64'd0);
    endtask

    task automatic t_handshake;
        chk("R2 ready", {63'd0, req_ready}, 64'd1);
        access(1'b0, 12'h010, 2'd0, '0);
        chk("R2 rsp valid", {63'd0, g_valid}, 64'd1);
        @(posedge clk); #1;
        chk("R2 idle no rsp", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_read_sizes;
        access(1'b0, 12'h011, 2'd0, '0);
        chk("R3 byte", g_data, 64'h0000_0000_0000_00FF);
        access(1'b0, 12'h010, 2'd1, '0);
        chk("R3 half", g_data, 64'h0000_0000_0000_FF00);
        access(1'b0, 12'h010, 2'd2, '0);
        chk("R3 word", g_data, 64'h0000_0000_0000_FF00);
        access(1'b0, 12'h030, 2'd3, '0);
        chk("R3 physical ring alias", g_data, 64'd0);
        chk("R3 no flag", {62'd0, g_err, g_unimp}, 64'd0);
    endtask

    task automatic t_unaligned;
        access(1'b0, 12'h011, 2'd1, '0);
        chk("R4 half data", g_data, ONES);
        chk("R4 half err", {63'd0, g_err}, 64'd1);
        access(1'b0, 12'h014, 2'd3, '0);
        chk("R4 dword data", g_data, ONES);
        chk("R4 dword err", {63'd0, g_err}, 64'd1);
    endtask

    task automatic t_prio_byte;
        access(1'b1, 12'h011, 2'd0, 64'h5);
        chk("R5 write flags", {62'd0, g_err, g_unimp}, 64'd0);
        chk("R11 write data zero", g_data, 64'd0);
        read_prio("R5 value 5", 8'h05);
        access(1'b1, 12'h011, 2'd0, 64'h7);
        read_prio("R5 boundary 7", 8'h07);
        access(1'b1, 12'h011, 2'd0, 64'h8);
        read_prio("R5 clamp 8", 8'hFF);
        access(1'b1, 12'h011, 2'd0, 64'h0);
        read_prio("R5 value 0", 8'h00);
        access(1'b1, 12'h011, 2'd0, 64'hA3);
        read_prio("R5 clamp A3", 8'hFF);
    endtask

    task automatic t_wide_write;
        access(1'b1, 12'h010, 2'd3, 64'h1122_3344_5566_7788);
        chk("R6 dword flags", {62'd0, g_err, g_unimp}, 64'd0);
        access(1'b0, 12'h010, 2'd3, '0);
        chk("R6 dword lane only", g_data, 64'h0000_0000_0000_7700);
        access(1'b1, 12'h010, 2'd2, 64'h0000_0000_0000_0300);
        read_prio("R6 word lane", 8'h03);
        access(1'b1, 12'h014, 2'd2, 64'hFFFF_FFFF);
        read_prio("R6 word not covering", 8'h03);
    endtask

    task automatic t_bad_writes;
        access(1'b1, 12'h010, 2'd1, 64'h0600);
        chk("R7 half err", {63'd0, g_err}, 64'd1);
        read_prio("R7 half no change", 8'h03);
        access(1'b1, 12'h012, 2'd0, 64'h2);
        chk("R7 byte other err", {63'd0, g_err}, 64'd1);
        access(1'b0, 12'h012, 2'd0, '0);
        chk("R7 byte other no change", g_data, 64'd0);
        access(1'b1, 12'h011, 2'd2, 64'h0200);
        chk("R7 unaligned word err", {63'd0, g_err}, 64'd1);
        read_prio("R7 unaligned no change", 8'h03);
    endtask

    task automatic t_unserved;
        access(1'b0, 12'h000, 2'd3, '0);
        chk("R8 user read data", g_data, ONES);
        chk("R8 user flags", {62'd0, g_err, g_unimp}, 64'd1);
        access(1'b0, 12'h020, 2'd0, '0);
        chk("R8 pool unimp", {63'd0, g_unimp}, 64'd1);
        access(1'b1, 12'h001, 2'd0, 64'h1);
        chk("R8 write unimp", {62'd0, g_err, g_unimp}, 64'd1);
        read_prio("R8 write no change", 8'h03);
    endtask

    task automatic t_commands;
        access(1'b0, 12'h810, 2'd1, '0);
        chk("R9 ack data", g_data, 64'd0);
        chk("R9 ack flags", {62'd0, g_err, g_unimp}, 64'd0);
        access(1'b0, 12'h810, 2'd0, '0);
        chk("R9 ack wrong size", g_data, ONES);
        chk("R9 ack wrong size err", {62'd0, g_err, g_unimp}, 64'd2);
        access(1'b0, 12'h818, 2'd3, '0);
        chk("R9 other cmd", g_data, ONES);
        access(1'b1, 12'h812, 2'd0, 64'h1);
        chk("R10 cmd write flags", {62'd0, g_err, g_unimp}, 64'd0);
        access(1'b1, 12'h811, 2'd0, 64'h6);
        chk("R10 cmd write flags alias", {62'd0, g_err, g_unimp}, 64'd0);
        read_prio("R10 no change", 8'h03);
    endtask

    logic done = 1'b0;

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_handshake();
        t_read_sizes();
        t_unaligned();
        t_prio_byte();
        t_wide_write();
        t_bad_writes();
        t_unserved();
        t_commands();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule